// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block owns the control-register side of a 32-bit core at the moments when control flow is taken away from the program or handed back to it. When the core signals an exception, a trap or an accepted interrupt, the block captures the return address, the status register and the stack pointer in one edge. It then forces the status register into privileged, blocked, bank-1 state and steers fetch to a vector address. When the core executes a return-from-exception, it restores the status register from its saved copy and redirects fetch to the saved return address after one delay-slot instruction.

The status register is held here. The four arithmetic flags live in the datapath and arrive on their own pins; the visible status value merges them into place. Any load of the status register that flips the register-bank select bit raises a one-cycle bank swap pulse, so the register file can exchange its eight low general registers with their banked copies. All outputs are registered and change on the clock edge that samples the request.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, tgt_pc is 0xA0000000, tgt_npc is 0xA0000002, the stored status register is 0x700000F0, and expevt, spc, ssr, sgr, intevt and tra are zero. redirect, irq_ack and bank_swap are low.
- R2: On exception or interrupt entry, spc takes cur_pc + 2, ssr takes the merged status value, and sgr takes r15. All three change on the edge that samples the request.
- R3: On entry, the new status register is the merged old value ORed with bit 30 (privileged), bit 28 (block) and bit 29 (bank select).
- R4: Exception kinds are encoded on exc_kind as follows: 0 illegal instruction, 1 illegal slot instruction, 2 trap, 3 FPU disabled, 4 manual reset, 5 power-on reset. Kinds 0 to 3 vector to vbr + 0x100, with modulo-2^32 wrap. Kinds 4 and 5 vector to 0xA0000000. tgt_npc is tgt_pc + 2, and redirect pulses for one cycle.
- R5: expevt takes 0x180, 0x1A0, 0x160, 0x800, 0x020 or 0x000 for kinds 0 to 5 respectively.
- R6: An interrupt request with no exception request writes irq_code into intevt and vectors to vbr + 0x600. It pulses irq_ack and redirect, and leaves expevt unchanged.
- R7: Requests in the same cycle follow the priority exception > interrupt > return > status write. A request that loses is dropped: intevt keeps its value, irq_ack stays low, and the return target is not taken.
- R8: bank_swap pulses for one cycle after any status-register load (entry, return or sr_wr_en write) that changes bit 29. It stays low when bit 29 is unchanged.
- R9: A trap (kind 2) stores trap_imm into tra. Other kinds and interrupts leave tra unchanged.
- R10: A return request loads the status register from ssr and sets tgt_pc to cur_pc + 2 (the delay slot) and tgt_npc to spc. It pulses redirect.
- R11: sr_value presents the stored status register with bit 0 replaced by t_in, bit 1 by s_in, bit 8 by q_in and bit 9 by m_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | Address of the current instruction |
| r15 | input | 32 | Current stack pointer register value |
| vbr | input | 32 | Vector base address |
| t_in | input | 1 | Datapath T flag |
| s_in | input | 1 | Datapath S flag |
| q_in | input | 1 | Datapath Q flag |
| m_in | input | 1 | Datapath M flag |
| exc_req | input | 1 | Exception request strobe |
| exc_kind | input | 3 | Exception kind (see R4) |
| trap_imm | input | 8 | Unsigned trap immediate |
| irq_req | input | 1 | Interrupt accepted at an instruction boundary |
| irq_code | input | 12 | Interrupt event code |
| rte_req | input | 1 | Return-from-exception strobe |
| sr_wr_en | input | 1 | Status register write strobe |
| sr_wr_data | input | 32 | Status register write value |
| tgt_pc | output | 32 | Redirected fetch address |
| tgt_npc | output | 32 | Address following tgt_pc |
| redirect | output | 1 | One-cycle pulse: fetch must use tgt_pc/tgt_npc |
| irq_ack | output | 1 | One-cycle pulse: interrupt taken |
| spc | output | 32 | Saved return address |
| ssr | output | 32 | Saved status register |
| sgr | output | 32 | Saved stack pointer |
| expevt | output | 12 | Last exception event code |
| intevt | output | 12 | Last interrupt event code |
| tra | output | 8 | Last trap immediate |
| sr_value | output | 32 | Status register with datapath flags merged |
| bank_swap | output | 1 | One-cycle pulse: exchange low register bank |

## Verification
The hardest situation to reach is a return that flips the bank select bit. Entry always forces the bit to 1, so a return can only clear it if ssr already holds a status value with that bit at 0. The stimulus first writes the status register to zero, which produces one swap. It then raises an exception, which saves that zero into ssr and swaps back. Finally it issues the return and expects a third swap. Priority is exercised by asserting exception, interrupt and return together in one cycle.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [2:0] {
    EK_ILLEGAL = 3'd0,
    EK_SLOT    = 3'd1,
    EK_TRAP    = 3'd2,
    EK_FPU_OFF = 3'd3,
    EK_MAN_RST = 3'd4,
    EK_PWR_RST = 3'd5
  } exc_kind_e;

  // status register bit positions decoded by neighbouring logic
  localparam int SR_T  = 0;
  localparam int SR_S  = 1;
  localparam int SR_Q  = 8;
  localparam int SR_M  = 9;
  localparam int SR_BL = 28;
  localparam int SR_RB = 29;
  localparam int SR_MD = 30;

  localparam int CODE_W = 12;

  localparam logic [CODE_W-1:0] EV_ILLEGAL = 12'h180;
  localparam logic [CODE_W-1:0] EV_SLOT    = 12'h1A0;
  localparam logic [CODE_W-1:0] EV_TRAP    = 12'h160;
  localparam logic [CODE_W-1:0] EV_FPU_OFF = 12'h800;
  localparam logic [CODE_W-1:0] EV_MAN_RST = 12'h020;
  localparam logic [CODE_W-1:0] EV_PWR_RST = 12'h000;

endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_seq_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int unsigned EXC_OFS  = 'h100,
  parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
  input  logic [2:0]        kind,
  input  logic [XLEN-1:0]   vbr,
  output logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   target
);

  logic [XLEN-1:0] general_tgt;
  assign general_tgt = vbr + XLEN'(EXC_OFS);

  always_comb begin
    code   = EV_ILLEGAL;
    target = general_tgt;
    case (exc_kind_e'(kind))
      EK_ILLEGAL: code = EV_ILLEGAL;
      EK_SLOT:    code = EV_SLOT;
      EK_TRAP:    code = EV_TRAP;
      EK_FPU_OFF: code = EV_FPU_OFF;
      EK_MAN_RST: begin
        code   = EV_MAN_RST;
        target = XLEN'(RESET_PC);
      end
      EK_PWR_RST: begin
        code   = EV_PWR_RST;
        target = XLEN'(RESET_PC);
      end
      default:    code = EV_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/exc_sr_unit.sv
module exc_sr_unit
  import exc_seq_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_SR = 32'h7000_00F0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [XLEN-1:0] load_val,
  input  logic            t_in,
  input  logic            s_in,
  input  logic            q_in,
  input  logic            m_in,
  output logic [XLEN-1:0] sr_value,
  output logic            bank_swap
);

  logic [XLEN-1:0] sr_q, sr_d;
  logic            swap_q, swap_d;

  always_comb begin
    sr_d   = load_val;
    swap_d = load_en && (load_val[SR_RB] != sr_q[SR_RB]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= XLEN'(RESET_SR);
      swap_q <= 1'b0;
    end else begin
      if (load_en) sr_q <= sr_d;
      swap_q <= swap_d;
    end
  end

  always_comb begin
    sr_value       = sr_q;
    sr_value[SR_T] = t_in;
    sr_value[SR_S] = s_in;
    sr_value[SR_Q] = q_in;
    sr_value[SR_M] = m_in;
  end

  assign bank_swap = swap_q;

  assert_swap_means_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bank_swap |-> (sr_q[SR_RB] != $past(sr_q[SR_RB])));

  assert_no_swap_same_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && (load_val[SR_RB] == sr_q[SR_RB])) |=> !bank_swap);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int unsigned INSN_BYTES = 2,
  parameter int unsigned EXC_OFS    = 'h100,
  parameter int unsigned IRQ_OFS    = 'h600,
  parameter logic [31:0] RESET_PC   = 32'hA000_0000,
  parameter logic [31:0] RESET_SR   = 32'h7000_00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   r15,
  input  logic [XLEN-1:0]   vbr,
  input  logic              t_in,
  input  logic              s_in,
  input  logic              q_in,
  input  logic              m_in,
  input  logic              exc_req,
  input  logic [2:0]        exc_kind,
  input  logic [7:0]        trap_imm,
  input  logic              irq_req,
  input  logic [CODE_W-1:0] irq_code,
  input  logic              rte_req,
  input  logic              sr_wr_en,
  input  logic [XLEN-1:0]   sr_wr_data,
  output logic [XLEN-1:0]   tgt_pc,
  output logic [XLEN-1:0]   tgt_npc,
  output logic              redirect,
  output logic              irq_ack,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   sgr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt,
  output logic [7:0]        tra,
  output logic [XLEN-1:0]   sr_value,
  output logic              bank_swap
);

  localparam logic [XLEN-1:0] STEP       = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] ENTRY_MASK =
    (XLEN'(1) << SR_MD) | (XLEN'(1) << SR_BL) | (XLEN'(1) << SR_RB);

  // request arbitration: exception > interrupt > return > status write
  logic take_exc, take_irq, take_rte, take_wr, take_entry;
  assign take_exc   = exc_req;
  assign take_irq   = irq_req && !exc_req;
  assign take_rte   = rte_req && !exc_req && !irq_req;
  assign take_wr    = sr_wr_en && !exc_req && !irq_req && !rte_req;
  assign take_entry = take_exc || take_irq;

  logic [CODE_W-1:0] vec_code;
  logic [XLEN-1:0]   vec_tgt;

  exc_vec_sel #(
    .XLEN     (XLEN),
    .EXC_OFS  (EXC_OFS),
    .RESET_PC (RESET_PC)
  ) u_vec (
    .kind   (exc_kind),
    .vbr    (vbr),
    .code   (vec_code),
    .target (vec_tgt)
  );

  logic            sr_load;
  logic [XLEN-1:0] sr_load_val;

  always_comb begin
    sr_load     = take_entry || take_rte || take_wr;
    sr_load_val = sr_wr_data;
    if (take_entry)    sr_load_val = sr_value | ENTRY_MASK;
    else if (take_rte) sr_load_val = ssr;
  end

  exc_sr_unit #(
    .XLEN     (XLEN),
    .RESET_SR (RESET_SR)
  ) u_sr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (sr_load),
    .load_val  (sr_load_val),
    .t_in      (t_in),
    .s_in      (s_in),
    .q_in      (q_in),
    .m_in      (m_in),
    .sr_value  (sr_value),
    .bank_swap (bank_swap)
  );

  // next-state
  logic [XLEN-1:0]   spc_d, ssr_d, sgr_d, pc_d, npc_d;
  logic [CODE_W-1:0] expevt_d, intevt_d;
  logic [7:0]        tra_d;
  logic              save_en, expevt_en, intevt_en, tra_en, redir_d;
  logic [XLEN-1:0]   entry_tgt;

  always_comb begin
    save_en   = take_entry;
    spc_d     = cur_pc + STEP;
    ssr_d     = sr_value;
    sgr_d     = r15;
    expevt_en = take_exc;
    expevt_d  = vec_code;
    intevt_en = take_irq;
    intevt_d  = irq_code;
    tra_en    = take_exc && (exc_kind == EK_TRAP);
    tra_d     = trap_imm;
    redir_d   = take_entry || take_rte;
    entry_tgt = take_exc ? vec_tgt : (vbr + XLEN'(IRQ_OFS));
    if (take_rte) begin
      pc_d  = cur_pc + STEP;
      npc_d = spc;
    end else begin
      pc_d  = entry_tgt;
      npc_d = entry_tgt + STEP;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spc      <= '0;
      ssr      <= '0;
      sgr      <= '0;
      expevt   <= EV_PWR_RST;
      intevt   <= '0;
      tra      <= '0;
      tgt_pc   <= XLEN'(RESET_PC);
      tgt_npc  <= XLEN'(RESET_PC) + STEP;
      redirect <= 1'b0;
      irq_ack  <= 1'b0;
    end else begin
      if (save_en) begin
        spc <= spc_d;
        ssr <= ssr_d;
        sgr <= sgr_d;
      end
      if (expevt_en) expevt <= expevt_d;
      if (intevt_en) intevt <= intevt_d;
      if (tra_en)    tra    <= tra_d;
      if (redir_d) begin
        tgt_pc  <= pc_d;
        tgt_npc <= npc_d;
      end
      redirect <= redir_d;
      irq_ack  <= take_irq;
    end
  end

  assert_save_r15_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (sgr == $past(r15)));

  assert_save_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (spc == $past(cur_pc) + STEP));

  assert_irq_priv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (sr_value[SR_MD] && sr_value[SR_BL] && sr_value[SR_RB]));

  assert_irq_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !exc_req) |=> (irq_ack && redirect && tgt_pc == $past(vbr) + XLEN'(IRQ_OFS)));

  assert_exc_over_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && irq_req) |=> (!irq_ack && $stable(intevt)));

  assert_rte_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rte_req && !exc_req && !irq_req) |=> (redirect && tgt_npc == $past(spc)));

endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] cur_pc, r15, vbr, sr_wr_data;
  logic        t_in, s_in, q_in, m_in;
  logic        exc_req, irq_req, rte_req, sr_wr_en;
  logic [2:0]  exc_kind;
  logic [7:0]  trap_imm;
  logic [11:0] irq_code;
  logic [31:0] tgt_pc, tgt_npc, spc, ssr, sgr, sr_value;
  logic        redirect, irq_ack, bank_swap;
  logic [11:0] expevt, intevt;
  logic [7:0]  tra;

  int total = 0;
  int bad   = 0;

  exc_entry_seq u_exc_entry_seq (
    .clk (clk), .rst_n (rst_n), .cur_pc (cur_pc), .r15 (r15), .vbr (vbr),
    .t_in (t_in), .s_in (s_in), .q_in (q_in), .m_in (m_in),
    .exc_req (exc_req), .exc_kind (exc_kind), .trap_imm (trap_imm),
    .irq_req (irq_req), .irq_code (irq_code), .rte_req (rte_req),
    .sr_wr_en (sr_wr_en), .sr_wr_data (sr_wr_data),
    .tgt_pc (tgt_pc), .tgt_npc (tgt_npc), .redirect (redirect), .irq_ack (irq_ack),
    .spc (spc), .ssr (ssr), .sgr (sgr), .expevt (expevt), .intevt (intevt),
    .tra (tra), .sr_value (sr_value), .bank_swap (bank_swap)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] vbr;
    logic [31:0] pc;
    logic [31:0] r15;
    logic [7:0]  imm;
    logic [11:0] code;
    logic [31:0] tgt;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{3'd5, 32'h8C00_0000, 32'h8C00_1230, 32'h1000_0001, 8'h00, 12'h000, 32'hA000_0000},
    '{3'd4, 32'h8C00_0000, 32'h8C00_2000, 32'h2000_0002, 8'h00, 12'h020, 32'hA000_0000},
    '{3'd0, 32'h8C00_0000, 32'h8C01_0000, 32'h3000_0003, 8'h00, 12'h180, 32'h8C00_0100},
    '{3'd2, 32'h0000_4000, 32'h0C00_0002, 32'h4000_0004, 8'hA5, 12'h160, 32'h0000_4100},
    '{3'd3, 32'hFFFF_FF80, 32'h0000_0000, 32'h5000_0005, 8'h3C, 12'h800, 32'h0000_0080},
    '{3'd1, 32'h8C00_1000, 32'h8C02_0020, 32'h6000_0006, 8'h00, 12'h1A0, 32'h8C00_1100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_reqs();
    exc_req  = 1'b0;
    irq_req  = 1'b0;
    rte_req  = 1'b0;
    sr_wr_en = 1'b0;
  endtask

  // inputs are set just after a negedge; this passes one posedge and returns at the next negedge
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] exp_tra;
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] exp_tra;
    rst_n = 1'b0;
    cur_pc = '0; r15 = '0; vbr = '0; sr_wr_data = '0;
    t_in = 0; s_in = 0; q_in = 0; m_in = 0;
    exc_kind = '0; trap_imm = '0; irq_code = '0;
    clear_reqs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 tgt_pc", tgt_pc, 32'hA000_0000);
    chk("R1 tgt_npc", tgt_npc, 32'hA000_0002);
    chk("R1 sr_value", sr_value, 32'h7000_00F0);
    chk("R1 expevt", {20'h0, expevt}, 32'h0);
    chk("R1 spc", spc, 32'h0);
    chk("R1 pulses", {29'h0, redirect, irq_ack, bank_swap}, 32'h0);

    // vector walk over every exception kind
    exp_tra = 8'h00;
    for (int i = 0; i < 6; i++) begin
      exc_req  = 1'b1;
      exc_kind = VECS[i].kind;
      vbr      = VECS[i].vbr;
      cur_pc   = VECS[i].pc;
      r15      = VECS[i].r15;
      trap_imm = VECS[i].imm;
      if (VECS[i].kind == 3'd2) exp_tra = VECS[i].imm;
      step();
      clear_reqs();
      chk("R2 spc", spc, VECS[i].pc + 32'd2);
      chk("R2 ssr", ssr, 32'h7000_00F0);
      chk("R2 sgr", sgr, VECS[i].r15);
      chk("R3 sr entry", sr_value, 32'h7000_00F0);
      chk("R4 tgt_pc", tgt_pc, VECS[i].tgt);
      chk("R4 tgt_npc", tgt_npc, VECS[i].tgt + 32'd2);
      chk("R4 redirect", {31'h0, redirect}, 32'h1);
      chk("R5 expevt", {20'h0, expevt}, {20'h0, VECS[i].code});
      chk("R9 tra", {24'h0, tra}, {24'h0, exp_tra});
      chk("R8 no swap", {31'h0, bank_swap}, 32'h0);
    end

    // R4 pulse width: one quiet cycle drops redirect
    step();
    chk("R4 redirect single", {31'h0, redirect}, 32'h0);

    // R8 status write flipping bank bit; R11 stored S bit hidden by s_in
    sr_wr_en = 1'b1; sr_wr_data = 32'h0000_0012;
    step();
    clear_reqs();
    chk("R8 swap on write", {31'h0, bank_swap}, 32'h1);
    chk("R11 s_in overrides", sr_value, 32'h0000_0010);
    chk("R10 no redirect on write", {31'h0, redirect}, 32'h0);

    // R8 write keeping bank bit
    sr_wr_en = 1'b1; sr_wr_data = 32'h0000_00F0;
    step();
    clear_reqs();
    chk("R8 no swap same bank", {31'h0, bank_swap}, 32'h0);

    // R11 flag merge
    t_in = 1'b1; m_in = 1'b1;
    #1;
    chk("R11 merge", sr_value, 32'h0000_02F1);

    // R6 interrupt entry with flags set, bank flips 0->1
    irq_req = 1'b1; irq_code = 12'h3C0; vbr = 32'h8C00_0000;
    cur_pc = 32'h8C00_5000; r15 = 32'hABCD_0000;
    step();
    clear_reqs();
    chk("R6 intevt", {20'h0, intevt}, 32'h3C0);
    chk("R6 irq_ack", {31'h0, irq_ack}, 32'h1);
    chk("R6 tgt_pc", tgt_pc, 32'h8C00_0600);
    chk("R6 tgt_npc", tgt_npc, 32'h8C00_0602);
    chk("R6 expevt kept", {20'h0, expevt}, 32'h1A0);
    chk("R2 irq ssr", ssr, 32'h0000_02F1);
    chk("R2 irq spc", spc, 32'h8C00_5002);
    chk("R3 irq sr", sr_value, 32'h7000_02F1);
    chk("R8 swap on entry", {31'h0, bank_swap}, 32'h1);
    chk("R9 tra kept by irq", {24'h0, tra}, 32'hA5);
    t_in = 1'b0; m_in = 1'b0;

    // R7 exception, interrupt and return together
    exc_req = 1'b1; exc_kind = 3'd0; irq_req = 1'b1; irq_code = 12'h5A0; rte_req = 1'b1;
    vbr = 32'h8C00_0000; cur_pc = 32'h8C00_6000;
    step();
    clear_reqs();
    chk("R7 no ack", {31'h0, irq_ack}, 32'h0);
    chk("R7 intevt kept", {20'h0, intevt}, 32'h3C0);
    chk("R7 expevt", {20'h0, expevt}, 32'h180);
    chk("R7 exc target", tgt_pc, 32'h8C00_0100);
    chk("R7 ssr", ssr, 32'h7000_00F0);

    // R10 return that clears the bank bit
    sr_wr_en = 1'b1; sr_wr_data = 32'h0;
    step();
    clear_reqs();
    chk("R8 swap write zero", {31'h0, bank_swap}, 32'h1);
    exc_req = 1'b1; exc_kind = 3'd0; cur_pc = 32'h8C00_7000;
    step();
    clear_reqs();
    chk("R2 ssr zero", ssr, 32'h0);
    chk("R3 forced bits", sr_value, 32'h7000_0000);
    chk("R8 swap entry", {31'h0, bank_swap}, 32'h1);
    rte_req = 1'b1; cur_pc = 32'h8C00_0104;
    step();
    clear_reqs();
    chk("R10 sr restored", sr_value, 32'h0);
    chk("R10 tgt_pc slot", tgt_pc, 32'h8C00_0106);
    chk("R10 tgt_npc spc", tgt_npc, 32'h8C00_7002);
    chk("R10 redirect", {31'h0, redirect}, 32'h1);
    chk("R8 swap on return", {31'h0, bank_swap}, 32'h1);
    chk("R10 expevt kept", {20'h0, expevt}, 32'h180);

    step();
    chk("R8 swap single", {31'h0, bank_swap}, 32'h0);
    chk("R6 ack quiet", {31'h0, irq_ack}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule